// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Read Master

This block sits in the fabric and runs read transactions against a slave on a narrow serial register bus. The bus moves two bits per clock in each direction, and it has a request line driven by this block and an acknowledge line driven by the slave. The user side hands over a 17-bit register address with a valid/ready handshake. The block turns the address into a nine-beat request frame. The first beat carries the read marker together with the lowest address bit, and each later beat carries the next two address bits.

After the frame, the block waits for the slave's acknowledge. Every clock in which the acknowledge is high, it shifts in one pair of returned data bits, starting with the least significant pair, until 32 bits have arrived. The word is then presented with a one-cycle response strobe. If the acknowledge does not arrive within a parameterised window, the block gives up, pulses a timeout flag and goes back to idle.

Back-pressure rules: `rd_ready` is high only while the block is idle. An `rd_valid` that is seen while `rd_ready` is low is dropped and is not held over for later. The response side has no ready input: `rsp_valid` is a single-cycle strobe, and `rsp_data` holds its value until the next completed read.

Top module: `sbr_read_master`

## Requirements
- R1: While `rst_async` is high, the outputs `sb_req`, `sb_dout`, `busy`, `rsp_valid`, `rsp_timeout` and `rsp_data` are all 0, and `rd_ready` is 1.
- R2: A read is accepted at a rising edge only if `rd_valid` is high and the block is idle (`rd_ready`=1). An `rd_valid` pulse while busy has no effect: the current frame keeps its address, and no extra frame or response follows.
- R3: `sb_req` rises in the cycle after acceptance, stays high for exactly 9 consecutive cycles, and then falls.
- R4: In the first cycle of the frame, `sb_dout[0]`=0 (read marker) and `sb_dout[1]`=A0.
- R5: In frame cycle k (k=2..9), `sb_dout[1]`=A(2k-2) and `sb_dout[0]`=A(2k-3). This gives the pairs {A2,A1} up to {A16,A15}.
- R6: Outside the 9 frame cycles, `sb_req` and `sb_dout` are both 0.
- R7: Each cycle in which `sb_ack` is high after the frame, the block captures one `sb_din` pair. Pair j forms bits [2j+1:2j] of the word, and cycles with `sb_ack` low in between are skipped without loss.
- R8: The edge that takes the 16th pair raises `rsp_valid` for one cycle with the word on `rsp_data`. `rsp_data` changes only in a cycle where `rsp_valid` is high.
- R9: If `sb_ack` stays low for ACK_WAIT cycles after the frame ends, `rsp_timeout` is high for one cycle, the block returns to idle, and `rsp_valid` is not raised. An acknowledge in the last cycle of the window is still taken.
- R10: `busy` (= !`rd_ready`) is high from the cycle after acceptance up to the cycle in which `rsp_valid` or `rsp_timeout` is high. In that cycle `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_async | input | 1 | Asynchronous reset, active high |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Block idle, request can be taken |
| rd_addr | input | 17 | Register address of the read |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_data | output | 32 | Returned word, held until the next completion |
| rsp_timeout | output | 1 | One-cycle strobe, acknowledge window expired |
| sb_req | output | 1 | Serial bus request line |
| sb_dout | output | 2 | Serial bus data towards the slave |
| sb_din | input | 2 | Serial bus data from the slave |
| sb_ack | input | 1 | Serial bus acknowledge from the slave |

## Verification
The bench builds the block with ACK_WAIT set to 8 and leaves the address and data widths at 17 and 32. The short window lets the sweep try every acknowledge delay from zero up to the last accepted cycle, plus the delay that expires. The sweep also covers every single-bit address and the all-zero and all-ones addresses, so each frame beat position and both timeout boundaries are checked. Some transactions add a gap in the acknowledge partway through the reply, and some add a stray request during the frame.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } sbr_state_e;
endpackage

// File: rtl/sbr_frame_tx.sv
module sbr_frame_tx #(
  parameter int ADDR_W = 17,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_async,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output logic              frame_end,
  output logic              req,
  output logic [LANE_W-1:0] dout
);
  localparam int NBEATS = (ADDR_W + 1) / LANE_W;
  localparam int SH_W   = ADDR_W - 1;
  localparam int CNT_W  = $clog2(NBEATS + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] beat_q;

  assign frame_end = req && (beat_q == CNT_W'(NBEATS - 1));

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      req    <= 1'b0;
      dout   <= '0;
      sh_q   <= '0;
      beat_q <= '0;
    end else if (load) begin
      req    <= 1'b1;
      dout   <= {addr[0], 1'b0};
      sh_q   <= addr[ADDR_W-1:1];
      beat_q <= '0;
    end else if (req) begin
      if (frame_end) begin
        req  <= 1'b0;
        dout <= '0;
      end else begin
        dout   <= sh_q[LANE_W-1:0];
        sh_q   <= sh_q >> LANE_W;
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbr_resp_rx.sv
module sbr_resp_rx #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_async,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [LANE_W-1:0] din,
  output logic              last,
  output logic [DATA_W-1:0] word_next
);
  localparam int NPAIRS = DATA_W / LANE_W;
  localparam int CNT_W  = $clog2(NPAIRS + 1);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;

  assign word_next = {din, word_q[DATA_W-1:LANE_W]};
  assign last      = shift_en && (cnt_q == CNT_W'(NPAIRS - 1));

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (shift_en) begin
      word_q <= word_next;
      cnt_q  <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbr_ack_timer.sv
module sbr_ack_timer #(
  parameter int ACK_WAIT = 256
) (
  input  logic clk,
  input  logic rst_async,
  input  logic waiting,
  input  logic ack,
  output logic expired
);
  localparam int CNT_W = $clog2(ACK_WAIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = waiting && !ack && (cnt_q == CNT_W'(ACK_WAIT - 1));

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async)            cnt_q <= '0;
    else if (!waiting || ack) cnt_q <= '0;
    else if (!expired)        cnt_q <= cnt_q + 1'b1;
    else                      cnt_q <= '0;
  end
endmodule

// File: rtl/sbr_read_master.sv
module sbr_read_master #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 2,
  parameter int ACK_WAIT = 256
) (
  input  logic              clk,
  input  logic              rst_async,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_timeout,
  output logic              sb_req,
  output logic [LANE_W-1:0] sb_dout,
  input  logic [LANE_W-1:0] sb_din,
  input  logic              sb_ack
);
  import sbr_pkg::*;

  sbr_state_e        state_q;
  logic              accept;
  logic              frame_end;
  logic              in_wait;
  logic              rx_en;
  logic              rx_last;
  logic              expired;
  logic [DATA_W-1:0] word_next;

  assign busy     = (state_q != ST_IDLE);
  assign rd_ready = !busy;
  assign accept   = rd_valid && !busy;
  assign in_wait  = (state_q == ST_WAIT);
  assign rx_en    = sb_ack && ((state_q == ST_WAIT) || (state_q == ST_RECV));

  sbr_frame_tx #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_tx (
    .clk       (clk),
    .rst_async (rst_async),
    .load      (accept),
    .addr      (rd_addr),
    .frame_end (frame_end),
    .req       (sb_req),
    .dout      (sb_dout)
  );

  sbr_resp_rx #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rx (
    .clk       (clk),
    .rst_async (rst_async),
    .clr       (accept),
    .shift_en  (rx_en),
    .din       (sb_din),
    .last      (rx_last),
    .word_next (word_next)
  );

  sbr_ack_timer #(.ACK_WAIT(ACK_WAIT)) u_timer (
    .clk       (clk),
    .rst_async (rst_async),
    .waiting   (in_wait),
    .ack       (sb_ack),
    .expired   (expired)
  );

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept)    state_q <= ST_SEND;
        ST_SEND: if (frame_end) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rx_last)      state_q <= ST_IDLE;
          else if (sb_ack)  state_q <= ST_RECV;
          else if (expired) state_q <= ST_IDLE;
        end
        ST_RECV: if (rx_last)   state_q <= ST_IDLE;
        default:                state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= rx_last;
      rsp_timeout <= expired;
      if (rx_last) rsp_data <= word_next;
    end
  end
endmodule

// File: rtl/sbr_read_master_chk.sv
module sbr_read_master_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_async,
  input logic              busy,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_timeout,
  input logic [DATA_W-1:0] rsp_data,
  input logic              sb_req,
  input logic [LANE_W-1:0] sb_dout
);
  localparam int NBEATS = (ADDR_W + 1) / LANE_W;

  logic [7:0] run_q;
  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async)   run_q <= '0;
    else if (sb_req) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_req_max_R3: assert property (@(posedge clk) disable iff (rst_async)
    sb_req |-> (run_q < 8'(NBEATS)));
  assert_req_len_R3: assert property (@(posedge clk) disable iff (rst_async)
    $fell(sb_req) |-> (run_q == 8'(NBEATS)));
  assert_read_flag_R4: assert property (@(posedge clk) disable iff (rst_async)
    $rose(sb_req) |-> (sb_dout[0] == 1'b0));
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst_async)
    !sb_req |-> (sb_dout == '0));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst_async)
    rsp_valid |=> !rsp_valid);
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst_async)
    !rsp_valid |-> $stable(rsp_data));
  assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (rst_async)
    rsp_timeout |=> !rsp_timeout);
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst_async)
    !(rsp_valid && rsp_timeout));
  assert_end_idle_R10: assert property (@(posedge clk) disable iff (rst_async)
    (rsp_valid || rsp_timeout) |-> (!busy && rd_ready && !sb_req));
  assert_ready_R2: assert property (@(posedge clk) disable iff (rst_async)
    sb_req |-> !rd_ready);
endmodule

bind sbr_read_master sbr_read_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
) i_chk (
  .clk         (clk),
  .rst_async   (rst_async),
  .busy        (busy),
  .rd_ready    (rd_ready),
  .rsp_valid   (rsp_valid),
  .rsp_timeout (rsp_timeout),
  .rsp_data    (rsp_data),
  .sb_req      (sb_req),
  .sb_dout     (sb_dout)
);

// File: tb/test_sbr_read_master.sv
`timescale 1ns/1ps
module test_sbr_read_master;
  localparam int AW = 17;
  localparam int DW = 32;
  localparam int WAITN = 8;

  logic          clk = 1'b0;
  logic          rst_async = 1'b1;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_timeout;
  logic          sb_req;
  logic [1:0]    sb_dout;
  logic [1:0]    sb_din = '0;
  logic          sb_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_data = '0;

  always #2 clk = ~clk;

  sbr_read_master #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(2), .ACK_WAIT(WAITN)) i_sbr_read_master (
    .clk(clk), .rst_async(rst_async), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_timeout(rsp_timeout), .sb_req(sb_req), .sb_dout(sb_dout),
    .sb_din(sb_din), .sb_ack(sb_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen_data(input logic [AW-1:0] a, input int d);
    return ({15'd0, a} * 32'd2654435) ^ (32'h0101_0101 * 32'(d + 1)) ^ 32'hA5C3_0F96;
  endfunction

  // One read: delay d before ack (d >= WAITN means no ack), optional ack gap and stray request.
  task automatic do_read(input logic [AW-1:0] a, input int d, input bit gap, input bit stray);
    logic [AW-1:0] got;
    logic [DW-1:0] exp;
    int seen;
    got = '0;
    exp = gen_data(a, d);
    @(negedge clk);
    rd_addr = a; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0; rd_addr = ~a;
    for (int k = 0; k < 9; k++) begin
      chk(sb_req === 1'b1, "R3 req high in frame", {31'd0, sb_req}, 32'd1);
      chk(busy === 1'b1 && rd_ready === 1'b0, "R10 busy during frame", {31'd0, busy}, 32'd1);
      if (k == 0) begin
        chk(sb_dout[0] === 1'b0, "R4 read marker", {30'd0, sb_dout}, {30'd0, a[0], 1'b0});
        got[0] = sb_dout[1];
      end else begin
        got[2*k-1] = sb_dout[0];
        got[2*k]   = sb_dout[1];
      end
      if (stray && k == 3) rd_valid = 1'b1;
      if (stray && k == 4) rd_valid = 1'b0;
      @(negedge clk);
    end
    chk(got === a, "R5 frame address (R2 stray ignored)", {15'd0, got}, {15'd0, a});
    chk(sb_req === 1'b0 && sb_dout === 2'b00, "R6 lines low after frame", {29'd0, sb_req, sb_dout}, 32'd0);
    if (d >= WAITN) begin
      seen = -1;
      for (int k = 1; k <= WAITN + 2; k++) begin
        @(negedge clk);
        if (rsp_timeout === 1'b1 && seen < 0) begin
          seen = k;
          chk(busy === 1'b0 && rsp_valid === 1'b0, "R9 idle on timeout, no response", {30'd0, busy, rsp_valid}, 32'd0);
        end
      end
      chk(seen == WAITN, "R9 timeout cycle", 32'(seen), 32'(WAITN));
      chk(rsp_data === last_data, "R8 data held after timeout", rsp_data, last_data);
    end else begin
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        chk(rsp_timeout === 1'b0 && busy === 1'b1, "R9 no early timeout", {30'd0, rsp_timeout, busy}, 32'd1);
      end
      for (int j = 0; j < DW/2; j++) begin
        if (gap && j == 8) begin
          sb_ack = 1'b0; sb_din = 2'b11;
          @(negedge clk);
        end
        sb_ack = 1'b1; sb_din = exp[2*j +: 2];
        @(negedge clk);
        if (j < DW/2 - 1)
          chk(rsp_valid === 1'b0 && busy === 1'b1, "R10 busy while receiving", {30'd0, rsp_valid, busy}, 32'd1);
      end
      sb_ack = 1'b0; sb_din = 2'b00;
      chk(rsp_valid === 1'b1, "R8 done strobe", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_data === exp, "R7 returned word", rsp_data, exp);
      chk(busy === 1'b0 && rd_ready === 1'b1, "R10 idle at done", {30'd0, busy, rd_ready}, 32'd1);
      chk(rsp_timeout === 1'b0, "R9 no timeout on success", {31'd0, rsp_timeout}, 32'd0);
      last_data = exp;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R8 single-cycle strobe", {31'd0, rsp_valid}, 32'd0);
      chk(rsp_data === exp, "R8 data held", rsp_data, exp);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(sb_req === 1'b0 && busy === 1'b0, "R2 no extra frame", {30'd0, sb_req, busy}, 32'd0);
    end
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sb_req === 1'b0 && sb_dout === 2'b00 && busy === 1'b0 && rd_ready === 1'b1,
        "R1 reset lines", {28'd0, sb_req, sb_dout, busy}, 32'd0);
    chk(rsp_valid === 1'b0 && rsp_timeout === 1'b0 && rsp_data === '0,
        "R1 reset response", rsp_data, 32'd0);
    rst_async = 1'b0;
    @(negedge clk);
    chk(rd_ready === 1'b1, "R1 ready after reset", {31'd0, rd_ready}, 32'd1);
    for (int b = 0; b < AW; b++)
      do_read(AW'(1) << b, b % WAITN, (b % 3) == 0, (b % 2) == 1);
    for (int d = 0; d < WAITN; d++)
      do_read(AW'(17'h1_2345 + d * 777), d, d[0], ~d[0]);
    do_read('0, 0, 1'b0, 1'b1);
    do_read({AW{1'b1}}, WAITN - 1, 1'b1, 1'b1);
    do_read(17'h0_ABCD, WAITN, 1'b0, 1'b1);
    do_read(17'h1_5555, 3, 1'b0, 1'b0);
    do_read(17'h0_AAAA, WAITN, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule